// File: doc/BRIEF.md
# Era-Extended Wall-Clock Time Keeper

This block keeps wall-clock time inside a packet pipeline without ever writing to the hardware timestamp counter. The pipeline supplies a free-running nanosecond counter that wraps at 2^CNT_W. The keeper stores three values:

- a reference time;
- the counter value captured when that reference was loaded (the offset);
- an era term that grows by 2^CNT_W each time the counter wraps.

Current time is rebuilt on demand as reference + (counter − offset) + era, and is always TIME_W bits wide.

A new reference may come from an external time source or from a synchronisation adjustment. Each load re-captures the offset and clears the era. A wrap is recognised when the counter value is smaller than its value in the previous cycle. For that reason the counter must advance by less than 2^CNT_W between cycles. The subtraction is done at TIME_W width. A wrap that falls between the offset capture and the readout therefore leaves a negative term, and the era term cancels it exactly.

A readout request is answered one cycle later with a valid strobe. The answer reflects any load or wrap seen in the same cycle as the request.

Top module: `timekeeper`

## Requirements
- R1: After reset, timeValid and timeOut are zero, and the reference, offset and era are zero. A read made before any load therefore returns the counter value, zero-extended.
- R2: timeValid is high in exactly the cycles that follow a cycle with rdReq high.
- R3: A read issued in the same cycle as a load returns loadTime exactly.
- R4: After a load at counter value c, and with no wrap in between, a read at counter value t returns loadTime + (t − c).
- R5: Each cycle in which tsNow is lower than its value in the previous cycle counts as a wrap and adds 2^CNT_W to the era term. Between two consecutive reads with no load in the second cycle, timeOut grows by (tsNow difference) mod 2^CNT_W.
- R6: When the counter wraps and ends below the offset, the reported time still equals loadTime plus the true number of elapsed nanoseconds.
- R7: When a load and a wrap occur in the same cycle, the load wins and the era is cleared. Time then continues from loadTime.
- R8: With no load between them, successive readouts never decrease.
- R9: A read in the cycle where a wrap is detected already includes that wrap's era step.
- R10: A later load replaces both the reference and the offset. Elapsed time is then measured from the new counter capture.
- R11: Without a read request, timeOut keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tsNow | input | CNT_W | Free-running nanosecond counter from the pipeline |
| loadEn | input | 1 | Load a new reference time this cycle |
| loadTime | input | TIME_W | New reference time |
| rdReq | input | 1 | Request a time readout |
| timeValid | output | 1 | Readout strobe, one cycle after rdReq |
| timeOut | output | TIME_W | Reported current time |

## Verification
The assertions check the following on every cycle:
- the valid strobe follows the request by one cycle;
- a read that coincides with a load returns the loaded value;
- back-to-back reads with no load are non-decreasing and differ by exactly the counter step modulo 2^CNT_W, which covers the era step at a wrap.

Some behaviours can be shown only by the bench's scenarios, which compare every readout against an independently accumulated nanosecond total:
- the absolute value after a load;
- the load-beats-wrap case;
- reloading at a new offset;
- readouts across many wraps with varied counter steps.

// File: rtl/timekeeper_pkg.sv
package timekeeper_pkg;
  // Strobes issued by the control path to the datapath each cycle.
  typedef struct packed {
    logic loadRef;  // take new reference, recapture offset, clear era
    logic eraStep;  // counter wrapped: advance era by one counter span
    logic capture;  // register current time onto the output
  } tkStrobes_t;
endpackage

// File: rtl/tk_ctrl.sv
module tk_ctrl
  import timekeeper_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] tsNow,
  input  logic             loadEn,
  input  logic             rdReq,
  output tkStrobes_t       strb,
  output logic             timeValid
);
  logic [CNT_W-1:0] prevTs;
  logic             wrapSeen;

  // A drop in the counter value means it passed all-ones to zero.
  assign wrapSeen = (tsNow < prevTs);

  always_comb begin
    strb.loadRef = loadEn;
    strb.eraStep = wrapSeen && !loadEn;  // a load overrides a coincident wrap
    strb.capture = rdReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTs    <= '0;
      timeValid <= 1'b0;
    end else begin
      prevTs    <= tsNow;
      timeValid <= rdReq;
    end
  end
endmodule

// File: rtl/tk_datapath.sv
module tk_datapath
  import timekeeper_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  tsNow,
  input  logic [TIME_W-1:0] loadTime,
  input  tkStrobes_t        strb,
  output logic [TIME_W-1:0] timeOut
);
  localparam int PAD_W = TIME_W - CNT_W;
  localparam logic [TIME_W-1:0] ERA_UNIT = {{(TIME_W-1){1'b0}}, 1'b1} << CNT_W;

  logic [TIME_W-1:0] refReg, eraReg, refNext, eraNext, nowTime;
  logic [CNT_W-1:0]  offReg, offNext;
  logic [TIME_W-1:0] tsExt, offExt;

  always_comb begin
    refNext = strb.loadRef ? loadTime : refReg;
    offNext = strb.loadRef ? tsNow : offReg;
    if (strb.loadRef)      eraNext = '0;
    else if (strb.eraStep) eraNext = eraReg + ERA_UNIT;
    else                   eraNext = eraReg;
    tsExt  = {{PAD_W{1'b0}}, tsNow};
    offExt = {{PAD_W{1'b0}}, offNext};
    // Full-width subtraction: a wrap below the offset goes negative and
    // the era term restores it.
    nowTime = refNext + (tsExt - offExt) + eraNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refReg  <= '0;
      offReg  <= '0;
      eraReg  <= '0;
      timeOut <= '0;
    end else begin
      refReg <= refNext;
      offReg <= offNext;
      eraReg <= eraNext;
      if (strb.capture) timeOut <= nowTime;
    end
  end
endmodule

// File: rtl/timekeeper.sv
module timekeeper
  import timekeeper_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  tsNow,
  input  logic              loadEn,
  input  logic [TIME_W-1:0] loadTime,
  input  logic              rdReq,
  output logic              timeValid,
  output logic [TIME_W-1:0] timeOut
);
  tkStrobes_t strb;

  tk_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tsNow(tsNow), .loadEn(loadEn),
    .rdReq(rdReq), .strb(strb), .timeValid(timeValid)
  );

  tk_datapath #(.CNT_W(CNT_W), .TIME_W(TIME_W)) uDp (
    .clk(clk), .rstN(rstN), .tsNow(tsNow), .loadTime(loadTime),
    .strb(strb), .timeOut(timeOut)
  );
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
  parameter int CNT_W  = 48,
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  tsNow,
  input logic              loadEn,
  input logic [TIME_W-1:0] loadTime,
  input logic              rdReq,
  input logic              timeValid,
  input logic [TIME_W-1:0] timeOut
);
  localparam int PAD_W = TIME_W - CNT_W;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> timeValid);  // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !timeValid);  // R2
  AST_LOAD_READ_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && loadEn) |=> (timeOut == $past(loadTime)));  // R3
  AST_READ_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (timeValid && $past(timeValid) && !$past(loadEn)) |-> (timeOut >= $past(timeOut)));  // R8
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (timeValid && $past(timeValid) && !$past(loadEn)) |->
      ((timeOut - $past(timeOut)) ==
       {{PAD_W{1'b0}}, CNT_W'($past(tsNow) - $past(tsNow, 2))}));  // R5
endmodule

bind timekeeper tk_checker #(.CNT_W(CNT_W), .TIME_W(TIME_W)) uChk (
  .clk(clk), .rstN(rstN), .tsNow(tsNow), .loadEn(loadEn), .loadTime(loadTime),
  .rdReq(rdReq), .timeValid(timeValid), .timeOut(timeOut)
);

// File: tb/sim_timekeeper.sv
module sim_timekeeper;
  localparam int CW = 8;
  localparam int TW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] tsNow = '0;
  logic          loadEn = 1'b0;
  logic [TW-1:0] loadTime = '0;
  logic          rdReq = 1'b0;
  logic          timeValid;
  logic [TW-1:0] timeOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Independent model: true nanoseconds accumulated from counter steps.
  logic [TW-1:0] modelNs = '0;
  logic [CW-1:0] mPrev = '0;
  logic [TW-1:0] lastOut = '0;

  always #5 clk = ~clk;

  timekeeper #(.CNT_W(CW), .TIME_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .tsNow(tsNow), .loadEn(loadEn),
    .loadTime(loadTime), .rdReq(rdReq), .timeValid(timeValid), .timeOut(timeOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [TW-1:0] act,
                     input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [CW-1:0] ts, input logic ld,
                     input logic [TW-1:0] lv, input logic rd, input string tag);
    logic [CW-1:0] d;
    tsNow = ts; loadEn = ld; loadTime = lv; rdReq = rd;
    d = ts - mPrev;
    modelNs = modelNs + {{(TW-CW){1'b0}}, d};
    mPrev = ts;
    if (ld) modelNs = lv;
    @(posedge clk);
    @(negedge clk);
    if (rd) begin
      chk(timeValid === 1'b1, "R2", {63'b0, timeValid}, 64'd1);
      chk(timeOut === modelNs, tag, timeOut, modelNs);
      lastOut = modelNs;
    end else begin
      chk(timeValid === 1'b0, "R2", {63'b0, timeValid}, 64'd0);
      chk(timeOut === lastOut, "R11", timeOut, lastOut);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [CW-1:0] ts;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(timeValid === 1'b0, "R1", {63'b0, timeValid}, 64'd0);
    chk(timeOut === '0, "R1", timeOut, 64'd0);
    rstN = 1'b1;

    cyc(8'd5, 0, 0, 1, "R1");           // no load yet: time = counter = 5
    cyc(8'd20, 1, 64'd1000, 1, "R3");   // read with load -> 1000
    cyc(8'd30, 0, 0, 1, "R4");          // 1010
    cyc(8'd31, 0, 0, 0, "R11");         // no read, output holds
    cyc(8'd250, 0, 0, 1, "R4");         // 1230
    cyc(8'd4, 0, 0, 1, "R9");           // wrap in read cycle, below offset: 1240
    cyc(8'd15, 0, 0, 1, "R6");          // 1251
    cyc(8'd200, 0, 0, 1, "R5");
    cyc(8'd3, 1, 64'd5000, 1, "R7");    // load and wrap together -> 5000
    cyc(8'd10, 0, 0, 1, "R7");          // 5007
    cyc(8'd100, 1, 64'd9000, 0, "R10");
    cyc(8'd120, 0, 0, 1, "R10");        // 9020

    // Sweep: varied counter steps, many wraps, scattered loads and reads.
    ts = 8'd120;
    for (int i = 0; i < 3000; i++) begin
      logic [CW-1:0] step;
      logic ld, rd;
      step = (i % 7 == 3) ? CW'((i * 73 + 11) % 256) : CW'((i * 37) % 29);
      ts = ts + step;
      ld = (i % 97 == 5) || ((i % 211 == 17) && (ts < mPrev));
      rd = (i % 5 != 2);
      cyc(ts, ld, TW'(i) * 64'd1000003, rd, ld ? "R7" : "R8");
    end
    finishRun();
  end
endmodule